// File: doc/BRIEF.md
# Oversampled serial receiver with break recognition

This block receives asynchronous serial characters on a single input line. It does not generate its own bit timing. A sample enable arrives sixteen times per bit period, and the receiver counts these pulses to find fixed points inside each bit. A falling line is confirmed as a start bit by a three-sample vote. The receiver then collects eight or nine data bits, least significant first, plus an optional parity bit, and finally judges the stop position. A completed character is placed in a holding register and a full flag is raised. Status flags report a missing stop bit, a parity mismatch, sample disagreement (noise) and loss of a character because the holder was still full. A single-cycle read strobe empties the holder.

An all-zero character is treated as a line break. This covers every data bit, the parity position when parity is on, and the stop position. On a break the block raises the framing error and full flags and loads zero into the holder. It then refuses to hunt for a new start bit until the line has been seen high again.

The control state machine has six states. IDLE looks for a low sample. START votes on the start bit. DATA collects the data bits. PARITY reads the parity bit. STOP judges the stop position. BRKWAIT waits for the line to go high after a break. The transitions are:
- IDLE→START on a low sample.
- START→IDLE when the vote is high (false start).
- START→DATA at the end of the start bit.
- DATA→PARITY or DATA→STOP after the last data bit, depending on whether parity is on.
- PARITY→STOP after the parity bit.
- STOP→IDLE after a normal character.
- STOP→BRKWAIT after a break.
- BRKWAIT→IDLE on a high sample.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, rx_data is zero, every flag output is low and the receiver is in IDLE.
- R2: Sample enables are numbered 1 to 16 within a bit, and the first low sample seen in IDLE counts as number 1. A start bit is accepted only if the majority of samples 3, 5 and 7 is low. Otherwise the receiver returns to IDLE and the holder and flags are unchanged.
- R3: Each data bit is the majority of its samples 7, 8 and 9, and bits arrive least significant first. With nine_bit=1 there are 9 data bits in rx_data[8:0]. With nine_bit=0 there are 8 data bits in rx_data[7:0], and rx_data[8] reads 0.
- R4: With par_en=1, one parity bit follows the data. par_err is set when the count of ones over the data and parity bits is odd with par_odd=0, or even with par_odd=1.
- R5: A character whose stop sample is 0, and which is not a break, sets frame_err and keeps its received data in rx_data.
- R6: A break is an accepted character in which the start bit, all data bits, the parity bit (when enabled) and the stop sample are all 0. A break sets frame_err and rx_full and makes rx_data zero.
- R7: After a break, no start bit is accepted until a high sample has been taken. rx_active stays low while the line remains low.
- R8: noise is set for an accepted character if any sample triple disagrees: the start triple or any data, parity or stop triple.
- R9: If a character completes while rx_full is 1 and no read is strobed, overrun is set. The new character is dropped, and rx_data and the other flags keep their values.
- R10: rd_strobe clears rx_full, frame_err, par_err, noise and overrun, and rx_data keeps its value. If rd_strobe falls in the same cycle as a character completes, the read acts first. The new character is accepted, rx_full stays 1 and overrun stays 0.
- R11: rx_active goes high in the cycle after start detection. It goes low in the cycle after the stop sample is judged, or after a start bit is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Sample enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_strobe | input | 1 | Read of the holder; clears full and flags |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Holder contains an unread character |
| frame_err | output | 1 | Stop sample was 0 |
| overrun | output | 1 | A character was dropped |
| noise | output | 1 | Sample disagreement in the last character |
| par_err | output | 1 | Parity mismatch in the last character |
| rx_active | output | 1 | Character reception in progress |

## Verification
Character completion and the read strobe can fall in the same clock cycle. That cycle decides between accepting the new character and flagging overrun. The bench provokes the case by leaving a character unread and then raising rd_strobe for exactly the enable cycle of the next character's stop sample. It judges the result by requiring rx_full to stay high, overrun to stay low, and rx_data and the flags to show the new character. Randomly mixed frames also overlap a break, parity, noise and a missing stop bit in one character. Each flag is compared with a model computed from the bits driven onto the line.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    localparam int DATA_MAX = 9;
    localparam int IDX_W    = $clog2(DATA_MAX);
    localparam int PH_W     = 4;
    localparam logic [PH_W-1:0] PH_LAST   = 4'd15;
    localparam logic [PH_W-1:0] ST_SAMP_A = 4'd2;
    localparam logic [PH_W-1:0] ST_SAMP_B = 4'd4;
    localparam logic [PH_W-1:0] ST_DEC    = 4'd6;
    localparam logic [PH_W-1:0] BT_SAMP_A = 4'd6;
    localparam logic [PH_W-1:0] BT_SAMP_B = 4'd7;
    localparam logic [PH_W-1:0] BT_DEC    = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;
endpackage

// File: rtl/uart_brk_sampler.sv
module uart_brk_sampler
    import uart_brk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rxd,
    input  logic [PH_W-1:0] ph,
    input  logic            in_start,
    output logic            vote,
    output logic            disagree
);
    logic s_a, s_b;
    logic cap_a, cap_b;

    always_comb begin
        cap_a = tick && (in_start ? (ph == ST_SAMP_A) : (ph == BT_SAMP_A));
        cap_b = tick && (in_start ? (ph == ST_SAMP_B) : (ph == BT_SAMP_B));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else begin
            if (cap_a) s_a <= rxd;
            if (cap_b) s_b <= rxd;
        end
    end

    always_comb begin
        vote     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
        disagree = !((s_a == s_b) && (s_b == rxd));
    end
endmodule

// File: rtl/uart_brk_shifter.sv
module uart_brk_shifter
    import uart_brk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr,
    input  logic [IDX_W-1:0]    idx,
    input  logic                bitv,
    output logic [DATA_MAX-1:0] word
);
    for (genvar i = 0; i < DATA_MAX; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word[i] <= 1'b0;
            else if (clr)
                word[i] <= 1'b0;
            else if (wr && (idx == IDX_W'(i)))
                word[i] <= bitv;
        end
    end
endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status
    import uart_brk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic                brk,
    input  logic                fe_in,
    input  logic                pe_in,
    input  logic                ne_in,
    input  logic [DATA_MAX-1:0] word,
    input  logic                rd,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_full,
    output logic                frame_err,
    output logic                overrun,
    output logic                noise,
    output logic                par_err
);
    logic accept;
    assign accept = done && (!rx_full || rd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
            noise     <= 1'b0;
            par_err   <= 1'b0;
        end else if (accept) begin
            rx_data   <= brk ? '0 : word;
            rx_full   <= 1'b1;
            frame_err <= fe_in;
            par_err   <= pe_in;
            noise     <= ne_in;
            overrun   <= 1'b0;
        end else if (done) begin
            overrun   <= 1'b1;
        end else if (rd) begin
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            noise     <= 1'b0;
            overrun   <= 1'b0;
        end
    end

    // R6: a taken break leaves zero data, framing error and full
    a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && brk && (!rx_full || rd)) |=> (rx_data == '0 && frame_err && rx_full));
    // R9: dropped character keeps the holder
    a_r9_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !rd) |=> (overrun && rx_full && $stable(rx_data)));
    // R10: read empties the holder
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!rx_full && !overrun && !frame_err));
    // R10: read in the completion cycle lets the new character in
    a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd) |=> (rx_full && !overrun));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic                nine_bit,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                rd_strobe,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_full,
    output logic                frame_err,
    output logic                overrun,
    output logic                noise,
    output logic                par_err,
    output logic                rx_active
);
    rx_state_e        state, state_n;
    logic [PH_W-1:0]  ph, ph_n;
    logic [IDX_W-1:0] bidx, bidx_n;
    logic             nacc, nacc_n;
    logic             pacc, pacc_n;
    logic             allz, allz_n;
    logic             perr, perr_n;

    logic             vote, disagree;
    logic             done, brk, fe_bit, ne_bit, clr, wr;
    logic [IDX_W-1:0] last_idx;
    logic [DATA_MAX-1:0] word;

    assign last_idx = nine_bit ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);

    uart_brk_sampler u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rxd      (rxd),
        .ph       (ph),
        .in_start (state == ST_START),
        .vote     (vote),
        .disagree (disagree)
    );

    uart_brk_shifter u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr    (wr),
        .idx   (bidx),
        .bitv  (vote),
        .word  (word)
    );

    uart_brk_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .brk       (brk),
        .fe_in     (fe_bit),
        .pe_in     (perr),
        .ne_in     (ne_bit),
        .word      (word),
        .rd        (rd_strobe),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .frame_err (frame_err),
        .overrun   (overrun),
        .noise     (noise),
        .par_err   (par_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
            bidx  <= '0;
            nacc  <= 1'b0;
            pacc  <= 1'b0;
            allz  <= 1'b1;
            perr  <= 1'b0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            bidx  <= bidx_n;
            nacc  <= nacc_n;
            pacc  <= pacc_n;
            allz  <= allz_n;
            perr  <= perr_n;
        end
    end

    // next state and frame events
    always_comb begin
        state_n = state;
        ph_n    = ph;
        bidx_n  = bidx;
        nacc_n  = nacc;
        pacc_n  = pacc;
        allz_n  = allz;
        perr_n  = perr;
        done    = 1'b0;
        brk     = 1'b0;
        fe_bit  = 1'b0;
        ne_bit  = nacc | disagree;
        clr     = 1'b0;
        wr      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (os_tick && !rxd) begin
                    state_n = ST_START;
                    ph_n    = 4'd1;
                    bidx_n  = '0;
                    nacc_n  = 1'b0;
                    pacc_n  = 1'b0;
                    allz_n  = 1'b1;
                    perr_n  = 1'b0;
                    clr     = 1'b1;
                end
            end
            ST_START: begin
                if (os_tick) begin
                    ph_n = ph + 4'd1;
                    if (ph == ST_DEC) begin
                        nacc_n = disagree;
                        if (vote) begin
                            state_n = ST_IDLE;
                            ph_n    = '0;
                        end
                    end else if (ph == PH_LAST) begin
                        state_n = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (os_tick) begin
                    ph_n = ph + 4'd1;
                    if (ph == BT_DEC) begin
                        wr     = 1'b1;
                        nacc_n = nacc | disagree;
                        pacc_n = pacc ^ vote;
                        allz_n = allz & ~vote;
                    end else if (ph == PH_LAST) begin
                        if (bidx == last_idx) begin
                            state_n = par_en ? ST_PARITY : ST_STOP;
                            bidx_n  = '0;
                        end else begin
                            bidx_n  = bidx + 1'b1;
                        end
                    end
                end
            end
            ST_PARITY: begin
                if (os_tick) begin
                    ph_n = ph + 4'd1;
                    if (ph == BT_DEC) begin
                        nacc_n = nacc | disagree;
                        allz_n = allz & ~vote;
                        perr_n = (pacc ^ vote) != par_odd;
                    end else if (ph == PH_LAST) begin
                        state_n = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (os_tick) begin
                    ph_n = ph + 4'd1;
                    if (ph == BT_DEC) begin
                        done    = 1'b1;
                        fe_bit  = !vote;
                        brk     = allz && !vote;
                        ph_n    = '0;
                        state_n = (allz && !vote) ? ST_BRKWAIT : ST_IDLE;
                    end
                end
            end
            ST_BRKWAIT: begin
                if (os_tick && rxd) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_active = (state == ST_START) || (state == ST_DATA) ||
                    (state == ST_PARITY) || (state == ST_STOP);
    end

    // R11: a low sample in IDLE starts reception
    a_r11_active_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && os_tick && !rxd) |=> rx_active);
    // R7: no new start while the line stays low after a break
    a_r7_hold_after_break: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKWAIT && !(os_tick && rxd)) |=> !rx_active);
    // R2: a high vote rejects the start bit
    a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && os_tick && ph == ST_DEC && vote) |=> !rx_active);
    // R11: judging the stop sample ends reception
    a_r11_active_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rx_active);
endmodule

// File: tb/uart_brk_rx_tb.sv
`timescale 1ns/100ps
module uart_brk_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, frame_err, overrun, noise, par_err, rx_active;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [8:0] e_data = '0;
    bit e_full = 0, e_fe = 0, e_or = 0, e_ne = 0, e_pe = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    uart_brk_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
        .frame_err(frame_err), .overrun(overrun), .noise(noise),
        .par_err(par_err), .rx_active(rx_active)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one sample enable; called and returns at a falling edge
    task automatic tk(input logic v, input bit rd_here);
        rxd = v;
        #1;
        while (!os_tick) begin
            @(negedge clk);
            #1;
        end
        rd_strobe = rd_here;
        @(posedge clk);
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_strobe = 1'b0;
        e_full = 0; e_fe = 0; e_or = 0; e_ne = 0; e_pe = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1/R3 rx_data"}, rx_data, e_data);
        chk({tag, " R10 rx_full"}, {8'd0, rx_full}, {8'd0, e_full});
        chk({tag, " R5 frame_err"}, {8'd0, frame_err}, {8'd0, e_fe});
        chk({tag, " R9 overrun"}, {8'd0, overrun}, {8'd0, e_or});
        chk({tag, " R8 noise"}, {8'd0, noise}, {8'd0, e_ne});
        chk({tag, " R4 par_err"}, {8'd0, par_err}, {8'd0, e_pe});
        chk({tag, " R11 rx_active"}, {8'd0, rx_active}, 9'd0);
    endtask

    // gbit: index of bit to glitch (0 start, 1.. data, then parity, stop), -1 none
    task automatic send_frame(input logic [8:0] d, input bit nine, input bit pen,
                              input bit podd, input bit pbit, input bit stopb,
                              input int gbit, input bit rd_same, input int tail_low);
        int nb;
        logic [8:0] dm;
        bit brk, acc;
        nine_bit = nine; par_en = pen; par_odd = podd;
        nb = nine ? 9 : 8;
        dm = nine ? d : {1'b0, d[7:0]};
        for (int i = 0; i < nb + 2 + (pen ? 1 : 0); i++) begin
            logic bv;
            bit is_stop;
            int gp;
            is_stop = (i == nb + 1 + (pen ? 1 : 0));
            if (i == 0) bv = 1'b0;
            else if (i <= nb) bv = dm[i-1];
            else if (!is_stop) bv = pbit;
            else bv = stopb;
            gp = (i == 0) ? 4 : 7;
            if (i == 1) chk("R11 active mid-frame", {8'd0, rx_active}, 9'd1);
            for (int k = 0; k < 16; k++) begin
                logic v;
                v = bv;
                if (gbit == i && k == gp) v = ~v;
                if (is_stop && k >= 10) v = 1'b1;
                if (is_stop && tail_low > 0) v = 1'b0;
                tk(v, rd_same && is_stop && k == 8);
            end
        end
        for (int k = 0; k < tail_low; k++) tk(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) tk(1'b1, 1'b0);
        brk = (dm == 9'd0) && (!pen || !pbit) && !stopb;
        acc = !e_full || rd_same;
        if (acc) begin
            e_data = brk ? 9'd0 : dm;
            e_full = 1;
            e_fe = !stopb;
            e_pe = pen && ((^dm ^ pbit) != podd);
            e_ne = (gbit >= 0);
            e_or = 0;
        end else begin
            e_or = 1;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        check_all("reset R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 8-bit plain frame
        send_frame(9'h0A5, 0, 0, 0, 0, 1, -1, 0, 0);
        check_all("R3 8-bit");
        do_read();
        check_all("R10 after read");
        chk("R10 data kept after read", rx_data, 9'h0A5);

        // R2 false start: low for samples 1..4 only
        for (int k = 0; k < 4; k++) tk(1'b0, 1'b0);
        for (int k = 0; k < 20; k++) tk(1'b1, 1'b0);
        check_all("R2 false start");

        // R3 9-bit with odd parity correct
        send_frame(9'h1C3, 1, 1, 1, ~^9'h1C3, 1, -1, 0, 0);
        check_all("R3/R4 9-bit parity");
        do_read();

        // R6 R7 long break then a normal frame
        send_frame(9'h000, 0, 0, 0, 0, 0, -1, 0, 40);
        check_all("R6 break");
        chk("R6 break frame_err", {8'd0, frame_err}, 9'd1);
        do_read();
        check_all("R7 after break read");
        send_frame(9'h03C, 0, 0, 0, 0, 1, -1, 0, 0);
        check_all("R7 frame after break");

        // R9 overrun: holder still full
        send_frame(9'h011, 0, 0, 0, 0, 1, -1, 0, 0);
        check_all("R9 overrun");
        // R10 same-cycle read with completion
        send_frame(9'h0F0, 0, 0, 0, 0, 1, 3, 1, 0);
        check_all("R10 same cycle");
        do_read();

        // R5 framing error with data kept
        send_frame(9'h081, 0, 0, 0, 0, 0, -1, 0, 0);
        check_all("R5 framing");
        do_read();

        // randomised mix
        for (int n = 0; n < 40; n++) begin
            logic [8:0] d;
            bit nine, pen, podd, pbit, stopb, rds;
            int g, nb;
            d = 9'($urandom);
            if ($urandom_range(99, 0) < 12) d = '0;
            nine = 1'($urandom);
            pen = 1'($urandom);
            podd = 1'($urandom);
            nb = nine ? 9 : 8;
            pbit = (^(nine ? d : {1'b0, d[7:0]})) ^ podd;
            if ($urandom_range(99, 0) < 20) pbit = ~pbit;
            if (d == 0 && $urandom_range(1, 0) == 1) pbit = 0;
            stopb = ($urandom_range(99, 0) >= 20);
            g = ($urandom_range(99, 0) < 25) ? $urandom_range(nb + 1 + (pen ? 1 : 0), 0) : -1;
            rds = ($urandom_range(99, 0) < 10);
            if ($urandom_range(99, 0) < 60 && !rds) do_read();
            send_frame(d, nine, pen, podd, pbit, stopb, g, rds, 0);
            check_all("random");
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule